// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Eight-Word Queue

This block is the sending half of a two-wire, return-to-zero avionics data link. A host writes each word as two 16-bit halves. The first strobe captures one half and the second strobe completes the word and queues it. Up to eight words wait in an on-chip queue. When the host raises transmit enable, the queue is sent as one burst: each word goes out least significant bit first, is closed by a parity bit computed while it is being shifted, and is followed by a fixed quiet gap. The burst runs until the queue is empty, and then a ready flag tells the host that a new batch may be written.

Two logic outputs feed an external line driver. One pulses for a one bit and the other pulses for a zero bit. Both stay low during the gap and while idle. Static inputs choose the word length (24 or 31 data bits), the parity sense and the bit rate (the system clock divided by 10 or by 80). A bit-rate clock output marks every bit slot of a burst. The word length, parity sense and rate are taken at the start of each word.

Top module: `a429_tx_serializer`

## Requirements
- R1: The queue holds 8 words. A pulse on `ld_first_i` captures `ld_data_i` as the low half. A pulse on `ld_second_i` queues the word {`ld_data_i`[14:0], low half}. Bit 15 of the second half is discarded, and stored bit 0 is sent first.
- R2: Several `ld_first_i` pulses before one `ld_second_i` pulse leave only the last captured half in the word.
- R3: A word completed while 8 words are already queued replaces the most recently queued word. The queue still holds 8 words, and the older 7 are kept in order.
- R4: Both strobes are ignored while `tx_en_i` is high or while a word is in progress. Nothing is captured or queued.
- R5: While `tx_en_i` is high, queued words are sent oldest first, back to back, until the queue is empty. In 31-bit mode with a rate divisor of 10, eight words take 2880 clock cycles from the first clock edge with enable high until `tx_ready_o` is seen high.
- R6: Each bit slot lasts DIV clock cycles. A one drives `line_hi_o` high and a zero drives `line_lo_o` high, for the first DIV/2 cycles of the slot only. The two outputs are never high together.
- R7: When `short_word_i` is 1, a word sends stored bits 0..23. When it is 0, the word sends stored bits 0..30. The data bits are followed by one parity bit that makes the total count of ones odd when `parity_even_i` is 0 and even when it is 1.
- R8: After the parity bit, both outputs stay low for 4 bit slots. The first pulse of the next word therefore starts 5×DIV cycles after the parity pulse started.
- R9: DIV is 10 when `rate_slow_i` is 0 and 80 when it is 1. `bit_clk_o` is high for the first half of every bit slot during a burst, gap slots included, and low while idle. Each bit pulse starts in the same cycle as a rising edge of `bit_clk_o`.
- R10: With `rst_n` low, the queue is emptied and any word in progress is dropped. `tx_ready_o` is then 1 and all line outputs are 0.
- R11: `tx_ready_o` is 1 exactly when the queue is empty and no word is in progress. It falls after the first word is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, DIV times the bit rate |
| rst_n | input | 1 | Active-low master reset |
| ld_first_i | input | 1 | Strobe capturing the low half of a word |
| ld_second_i | input | 1 | Strobe supplying the upper half and queuing the word |
| ld_data_i | input | 16 | Parallel half-word data |
| tx_en_i | input | 1 | Transmit enable; high sends the queue, low allows loading |
| short_word_i | input | 1 | 1 selects 24 data bits, 0 selects 31 |
| parity_even_i | input | 1 | 0 selects odd parity, 1 selects even parity |
| rate_slow_i | input | 1 | 0 divides the clock by 10 per bit, 1 by 80 |
| line_hi_o | output | 1 | Pulses for a one bit |
| line_lo_o | output | 1 | Pulses for a zero bit |
| bit_clk_o | output | 1 | Bit-rate clock, high in the first half of each slot |
| tx_ready_o | output | 1 | Queue empty and transmitter idle |

## Verification
A read or write pointer that slips shows up in the first word of the next burst. That word's pulse pattern differs from the queued data, or a word appears that was never loaded, or an expected word is missing when the ready flag rises. A wrong phase or bit counter shows up within one bit slot as a pulse of the wrong width or a slot interval that is not DIV. It can also show up as a gap other than five slots between parity and the next word. A wrong parity accumulator is caught on the last pulse of the affected word. A wrong queue count is caught as a drain time that is not 2880 cycles, or as a ready flag that is wrong after an ignored load or a reset.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/a429_tx_fifo.sv
// Two-half load staging plus a circular word queue.
// DEPTH must be a power of two so the pointers wrap naturally.
module a429_tx_fifo #(
    parameter int DEPTH  = 8,
    parameter int HALF_W = 16,
    parameter int WORD_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_first_i,
    input  logic              ld_second_i,
    input  logic [HALF_W-1:0] ld_data_i,
    input  logic              lock_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] head_o,
    output logic              empty_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int UPPER = WORD_W - HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0]             stage;
        logic [DEPTH-1:0][WORD_W-1:0]  mem;
        logic [AW-1:0]                 rd;
        logic [AW-1:0]                 wr;
        logic [CW-1:0]                 cnt;
    } fifo_s;

    fifo_s q, d;
    logic  push;
    logic  full;
    logic [WORD_W-1:0] word;
    logic  unused_msb;

    assign unused_msb = ^ld_data_i[HALF_W-1:UPPER];
    assign full = (q.cnt == CW'(DEPTH));
    assign push = ld_second_i && !lock_i;
    assign word = {ld_data_i[UPPER-1:0], q.stage};

    always_comb begin
        d = q;
        if (ld_first_i && !lock_i) begin
            d.stage = ld_data_i;
        end
        if (pop_i && (q.cnt != '0)) begin
            d.rd  = q.rd + AW'(1);
            d.cnt = q.cnt - CW'(1);
        end
        if (push) begin
            if (full) begin
                d.mem[q.wr - AW'(1)] = word;
            end else begin
                d.mem[q.wr] = word;
                d.wr  = q.wr + AW'(1);
                d.cnt = d.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_o  = q.mem[q.rd];
    assign empty_o = (q.cnt == '0);

    // R1: occupancy never exceeds the queue depth
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    // R3: completing a word while full keeps the queue full
    p_full_stays_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_i) |=> (q.cnt == CW'(DEPTH)));
    // R4: no growth while loading is locked out
    p_no_growth_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> (q.cnt <= $past(q.cnt)));
endmodule

// File: rtl/a429_tx_engine.sv
// Serializer: bit-slot timing, on-the-fly parity, inter-word gap.
module a429_tx_engine
    import a429_tx_pkg::*;
#(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4,
    parameter int WORD_W   = 31,
    parameter int SHORT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              short_word_i,
    input  logic              parity_even_i,
    input  logic              rate_slow_i,
    input  logic [WORD_W-1:0] head_i,
    input  logic              empty_i,
    output logic              pop_o,
    output logic              busy_o,
    output logic              line_hi_o,
    output logic              line_lo_o,
    output logic              bit_clk_o
);
    localparam int PW = $clog2(DIV_SLOW);
    localparam int BW = $clog2(WORD_W + 2);

    typedef struct packed {
        tx_state_e         st;
        logic [WORD_W-1:0] sh;
        logic [PW-1:0]     ph;
        logic [BW-1:0]     bn;
        logic              acc;
        logic              slow;
        logic              short_w;
        logic              even;
    } eng_s;

    eng_s q, d;
    logic [PW-1:0] ph_last;
    logic [PW-1:0] ph_half;
    logic [BW-1:0] ndata;
    logic          in_data;
    logic          cur_bit;
    logic          start;
    logic          launch;
    logic          drive;

    assign ph_last = q.slow ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
    assign ph_half = q.slow ? PW'(DIV_SLOW / 2) : PW'(DIV_FAST / 2);
    assign ndata   = q.short_w ? BW'(SHORT_W) : BW'(WORD_W);
    assign in_data = (q.bn < ndata);
    assign cur_bit = in_data ? q.sh[0] : (q.acc ^ ~q.even);
    assign start   = tx_en_i && !empty_i;

    always_comb begin
        d      = q;
        launch = 1'b0;
        unique case (q.st)
            TX_IDLE: launch = start;
            TX_DATA: begin
                if (q.ph == ph_last) begin
                    d.ph = '0;
                    if (in_data) begin
                        d.acc = q.acc ^ q.sh[0];
                        d.sh  = q.sh >> 1;
                        d.bn  = q.bn + BW'(1);
                    end else begin
                        d.st = TX_GAP;
                        d.bn = '0;
                    end
                end else begin
                    d.ph = q.ph + PW'(1);
                end
            end
            TX_GAP: begin
                if (q.ph == ph_last) begin
                    d.ph = '0;
                    if (q.bn == BW'(GAP_BITS - 1)) begin
                        d.bn = '0;
                        if (start) launch = 1'b1;
                        else       d.st   = TX_IDLE;
                    end else begin
                        d.bn = q.bn + BW'(1);
                    end
                end else begin
                    d.ph = q.ph + PW'(1);
                end
            end
            default: d.st = TX_IDLE;
        endcase
        if (launch) begin
            d.st      = TX_DATA;
            d.sh      = head_i;
            d.ph      = '0;
            d.bn      = '0;
            d.acc     = 1'b0;
            d.slow    = rate_slow_i;
            d.short_w = short_word_i;
            d.even    = parity_even_i;
        end
        pop_o = launch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign drive     = (q.st == TX_DATA) && (q.ph < ph_half);
    assign line_hi_o = drive && cur_bit;
    assign line_lo_o = drive && !cur_bit;
    assign busy_o    = (q.st != TX_IDLE);
    assign bit_clk_o = busy_o && (q.ph < ph_half);

    // R8: gap slots are null on both lines
    p_gap_null_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_GAP) |-> (!line_hi_o && !line_lo_o));
    // R6: second half of every slot is null
    p_second_half_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph >= ph_half) |-> (!line_hi_o && !line_lo_o));
    // R5: a word is never popped mid-word
    p_pop_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o && busy_o) |-> ((q.st == TX_GAP) && (q.ph == ph_last)));
endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer #(
    parameter int DEPTH    = 8,
    parameter int HALF_W   = 16,
    parameter int WORD_W   = 31,
    parameter int SHORT_W  = 24,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_first_i,
    input  logic              ld_second_i,
    input  logic [HALF_W-1:0] ld_data_i,
    input  logic              tx_en_i,
    input  logic              short_word_i,
    input  logic              parity_even_i,
    input  logic              rate_slow_i,
    output logic              line_hi_o,
    output logic              line_lo_o,
    output logic              bit_clk_o,
    output logic              tx_ready_o
);
    logic [WORD_W-1:0] head;
    logic              empty;
    logic              pop;
    logic              busy;
    logic              lock;

    assign lock       = tx_en_i || busy;
    assign tx_ready_o = empty && !busy;

    a429_tx_fifo #(
        .DEPTH (DEPTH),
        .HALF_W(HALF_W),
        .WORD_W(WORD_W)
    ) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_first_i (ld_first_i),
        .ld_second_i(ld_second_i),
        .ld_data_i  (ld_data_i),
        .lock_i     (lock),
        .pop_i      (pop),
        .head_o     (head),
        .empty_o    (empty)
    );

    a429_tx_engine #(
        .DIV_FAST(DIV_FAST),
        .DIV_SLOW(DIV_SLOW),
        .GAP_BITS(GAP_BITS),
        .WORD_W  (WORD_W),
        .SHORT_W (SHORT_W)
    ) engine_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en_i      (tx_en_i),
        .short_word_i (short_word_i),
        .parity_even_i(parity_even_i),
        .rate_slow_i  (rate_slow_i),
        .head_i       (head),
        .empty_i      (empty),
        .pop_o        (pop),
        .busy_o       (busy),
        .line_hi_o    (line_hi_o),
        .line_lo_o    (line_lo_o),
        .bit_clk_o    (bit_clk_o)
    );

    // R6: never both lines at once
    p_lines_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi_o && line_lo_o));
    // R11: ready implies a silent line
    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> (!line_hi_o && !line_lo_o && !bit_clk_o));
    // R9: a bit pulse lies inside the high phase of the bit clock
    p_pulse_in_bitclk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hi_o || line_lo_o) |-> bit_clk_o);
endmodule

// File: tb/a429_tx_serializer_tb.sv
module a429_tx_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_first = 1'b0;
    logic        ld_second = 1'b0;
    logic [15:0] ld_data = '0;
    logic        tx_en = 1'b0;
    logic        cfg_short = 1'b0;
    logic        cfg_even = 1'b0;
    logic        cfg_slow = 1'b0;
    logic        line_hi, line_lo, bit_clk, tx_ready;

    int checks = 0;
    int failures = 0;
    int mdl_cnt = 0;
    int pulses = 0;
    logic [30:0] exp_q[$];

    always #4 clk = ~clk;

    a429_tx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .ld_first_i(ld_first), .ld_second_i(ld_second),
        .ld_data_i(ld_data), .tx_en_i(tx_en), .short_word_i(cfg_short),
        .parity_even_i(cfg_even), .rate_slow_i(cfg_slow), .line_hi_o(line_hi),
        .line_lo_o(line_lo), .bit_clk_o(bit_clk), .tx_ready_o(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic strobe_first(input logic [15:0] v);
        @(negedge clk); ld_data = v; ld_first = 1'b1;
        @(negedge clk); ld_first = 1'b0;
    endtask

    task automatic strobe_second(input logic [15:0] v);
        @(negedge clk); ld_data = v; ld_second = 1'b1;
        @(negedge clk); ld_second = 1'b0;
    endtask

    // driver: loads a word and records what the queue should hold (R1, R3)
    task automatic load_word(input logic [30:0] w);
        strobe_first(w[15:0]);
        strobe_second({1'b1, w[30:16]});
        if (mdl_cnt == 8) exp_q[exp_q.size()-1] = w;
        else begin exp_q.push_back(w); mdl_cnt++; end
    endtask

    task automatic run_burst(output int cyc);
        cyc = 0;
        @(negedge clk); tx_en = 1'b1;
        do begin @(negedge clk); cyc++; end while (!tx_ready && cyc < 60000);
        tx_en = 1'b0;
        mdl_cnt = 0;
        chk(exp_q.size() == 0, "R5", "words left unsent", exp_q.size(), 0);
    endtask

    // monitor: decodes pulses into words and checks slot timing
    int   cyc_n = 0;
    int   last_start = -1;
    int   pstart = 0;
    int   nb = 0;
    logic [31:0] got = '0;
    logic prev_act = 1'b0;
    logic prev_bclk = 1'b0;

    always @(negedge clk) begin
        int div, nd;
        logic act;
        logic [31:0] expw;
        logic [30:0] w;
        logic par;
        cyc_n++;
        div = cfg_slow ? 80 : 10;
        nd  = cfg_short ? 24 : 31;
        act = line_hi | line_lo;
        if (!rst_n) begin
            nb = 0; last_start = -1; got = '0;
        end else begin
            if (act && !prev_act) begin
                pulses++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "pulse with no word queued", 1, 0);
                end else begin
                    got[nb] = line_hi;
                    chk(bit_clk && !prev_bclk, "R9", "bit clock edge at pulse", bit_clk, 1);
                    if (last_start >= 0) begin
                        if (nb == 0) chk(cyc_n - last_start == 5*div, "R8",
                                         "parity-to-next-word interval", cyc_n - last_start, 5*div);
                        else chk(cyc_n - last_start == div, "R9",
                                 "slot interval", cyc_n - last_start, div);
                    end
                    last_start = cyc_n;
                    nb++;
                    if (nb == nd + 1) begin
                        w = exp_q.pop_front();
                        expw = '0; par = 1'b0;
                        for (int k = 0; k < nd; k++) begin expw[k] = w[k]; par ^= w[k]; end
                        expw[nd] = cfg_even ? par : ~par;
                        chk(got == expw, "R7", "serial word", got, expw);
                        nb = 0; got = '0;
                    end
                end
                pstart = cyc_n;
            end
            if (!act && prev_act)
                chk(cyc_n - pstart == div/2, "R6", "pulse width", cyc_n - pstart, div/2);
            if (tx_ready) last_start = -1;
        end
        prev_act  = act;
        prev_bclk = bit_clk;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc, p0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(tx_ready == 1'b1, "R10", "ready in reset", tx_ready, 1);
        chk({line_hi, line_lo, bit_clk} == 3'b000, "R10", "lines in reset",
            {line_hi, line_lo, bit_clk}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R7 odd parity, 31-bit, fast
        load_word(31'h12345678);
        chk(tx_ready == 1'b0, "R11", "ready after first push", tx_ready, 0);
        load_word(31'h7FFFFFFF);
        load_word(31'h00000000);
        run_burst(cyc);
        chk(tx_ready == 1'b1, "R11", "ready after drain", tx_ready, 1);

        // R2 repeated first strobe, even parity
        cfg_even = 1'b1;
        strobe_first(16'hDEAD);
        load_word(31'h5A5AC3C3);
        load_word(31'h00010001);
        run_burst(cyc);

        // R7 short words, R9 slow rate
        cfg_short = 1'b1; cfg_slow = 1'b1;
        load_word(31'h00ABCDEF);
        load_word(31'h7F800001);
        run_burst(cyc);

        // R3 overflow, R5 drain time
        cfg_short = 1'b0; cfg_slow = 1'b0; cfg_even = 1'b0;
        for (int i = 0; i < 9; i++) load_word(31'h0100_0000 * i + 31'h11 * i + 31'h3);
        chk(exp_q.size() == 8, "R3", "model depth", exp_q.size(), 8);
        run_burst(cyc);
        chk(cyc == 2881, "R5", "eight-word drain cycles", cyc, 2881);

        // R4 loads ignored while enable high and idle
        @(negedge clk); tx_en = 1'b1;
        strobe_first(16'h1111); strobe_second(16'h2222);
        repeat (3) @(negedge clk);
        chk(tx_ready == 1'b1, "R4", "ready after locked load", tx_ready, 1);
        p0 = pulses;
        repeat (300) @(negedge clk);
        chk(pulses == p0, "R4", "pulses after locked load", pulses - p0, 0);
        tx_en = 1'b0;

        // R4 loads ignored during a word in progress
        load_word(31'h2468ACE1);
        @(negedge clk); tx_en = 1'b1;
        repeat (40) @(negedge clk);
        strobe_first(16'h3333); strobe_second(16'h4444);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!tx_ready && cyc < 2000);
        chk(tx_ready == 1'b1 && exp_q.size() == 0, "R4", "queue after busy load",
            exp_q.size(), 0);
        p0 = pulses;
        repeat (400) @(negedge clk);
        chk(pulses == p0, "R4", "no extra word sent", pulses - p0, 0);
        tx_en = 1'b0; mdl_cnt = 0;

        // R10 master reset empties the queue
        load_word(31'h0F0F0F0F);
        load_word(31'h70707070);
        chk(tx_ready == 1'b0, "R11", "ready with words queued", tx_ready, 0);
        @(negedge clk); rst_n = 1'b0;
        exp_q.delete(); mdl_cnt = 0;
        repeat (2) @(negedge clk);
        chk(tx_ready == 1'b1, "R10", "ready during reset", tx_ready, 1);
        rst_n = 1'b1;
        @(negedge clk); tx_en = 1'b1;
        p0 = pulses;
        repeat (500) @(negedge clk);
        chk(pulses == p0 && tx_ready == 1'b1, "R10", "queue empty after reset",
            pulses - p0, 0);
        tx_en = 1'b0;

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule